// File: doc/BRIEF.md
# Branch History Target Table

This block is a small, fully associative store that a fetch unit consults to guess where execution goes after a branch. Each slot keeps the address of a branch instruction, the address that branch last jumped to, and a 2-bit saturating confidence counter. The fetch stage presents its current PC. In the same cycle the table answers whether that PC is a known branch, whether it is expected to be taken, and which address fetch should use next.

When a branch resolves later in the pipeline, the update port writes back the branch address, the real outcome and the real target. A known branch has its counter stepped and its target refreshed. An unknown branch claims a free slot, or evicts one in round-robin order once every slot is in use. Because the counter needs two wrong outcomes in a row to change its guess, a loop branch that falls out of its loop once still keeps its taken prediction on the next visit.

Top module: `bht_table`

## Requirements
- R1: While rst_ni is low, and after it is released, all slots are empty, so every lookup misses until an update is made.
- R2: A lookup that matches no valid slot gives lk_hit_o=0, lk_taken_o=0, lk_target_o=0 and lk_next_pc_o = lk_pc_i + 4, which is the sequential fall-through.
- R3: A lookup that matches a slot gives lk_hit_o=1 and the stored target on lk_target_o in the same cycle. lk_taken_o equals bit 1 of the counter. lk_next_pc_o is the stored target when lk_taken_o is 1 and lk_pc_i + 4 when it is 0.
- R4: The counter encoding is 00 strong not-taken, 01 weak not-taken, 10 weak taken and 11 strong taken. A taken outcome adds one and a not-taken outcome subtracts one, and the value saturates at 00 and 11.
- R5: A branch that misses on the update port is written into a slot with its target. Its counter starts at 10 if the outcome was taken and at 01 if it was not.
- R6: An update that hits an existing slot replaces that slot's stored target with up_target_i.
- R7: A single contrary outcome does not change the prediction from a strong state. From 11, one not-taken update still predicts taken. From 00, one taken update still predicts not-taken.
- R8: A new branch takes the lowest-numbered free slot. When all 8 slots are valid, the victim is selected by a pointer that starts at slot 0 after reset and moves up by one, wrapping, after each replacement.
- R9: When a lookup and an update address the same branch in the same cycle, the lookup reports the state from before the update. The new state is visible from the next cycle.
- R10: No two valid slots ever hold the same branch address. Repeated updates of one branch occupy a single slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, empties the table |
| lk_pc_i | input | ADDR_W | Fetch PC to look up |
| lk_hit_o | output | 1 | PC matches a valid slot |
| lk_taken_o | output | 1 | Predicted taken |
| lk_target_o | output | ADDR_W | Stored target of the matching slot, 0 on a miss |
| lk_next_pc_o | output | ADDR_W | Predicted next fetch address |
| up_valid_i | input | 1 | Resolved branch update strobe |
| up_pc_i | input | ADDR_W | Address of the resolved branch |
| up_taken_i | input | 1 | Actual direction of the resolved branch |
| up_target_i | input | ADDR_W | Actual target of the resolved branch |

## Verification
The assertions check the following on every cycle: the fall-through address on a miss, the redirect to the reported target on a taken hit, that at most one slot matches any address, that the set of valid slots only grows between resets and stays unchanged without an update, and that a branch just updated hits on the next cycle. The counter arithmetic, the seeding of new slots and the loop-exit behaviour need the bench's scenarios. The same is true of the round-robin eviction order and the old-value read during a same-cycle collision. The bench covers these with an exhaustive sweep of every four-outcome history from both seed states, followed by a scan of which branches survived eviction.

// File: rtl/bht_pkg.sv
package bht_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_SNT = 2'b00;
  localparam ctr_t CTR_WNT = 2'b01;
  localparam ctr_t CTR_WT  = 2'b10;
  localparam ctr_t CTR_ST  = 2'b11;

  function automatic ctr_t ctr_step(ctr_t c, logic taken);
    if (taken) return (c == CTR_ST) ? CTR_ST : c + 2'd1;
    return (c == CTR_SNT) ? CTR_SNT : c - 2'd1;
  endfunction

  function automatic ctr_t ctr_seed(logic taken);
    return taken ? CTR_WT : CTR_WNT;
  endfunction
endpackage

// File: rtl/bht_match.sv
module bht_match #(
  parameter int N     = 8,
  parameter int AW    = 32,
  localparam int IW   = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0][AW-1:0] tags_i,
  input  logic [N-1:0]         valid_i,
  input  logic [AW-1:0]        key_i,
  output logic [N-1:0]         hit_vec_o,
  output logic                 hit_o,
  output logic [IW-1:0]        idx_o
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign hit_vec_o[i] = valid_i[i] && (tags_i[i] == key_i);
  end

  assign hit_o = |hit_vec_o;

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++)
      if (hit_vec_o[i]) idx_o = IW'(i);
  end
endmodule

// File: rtl/bht_victim.sv
module bht_victim #(
  parameter int N   = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  valid_i,
  input  logic          alloc_i,
  output logic [IW-1:0] idx_o
);
  logic [IW-1:0] rr_q, free_idx;
  logic          any_free;

  // lowest free slot wins
  always_comb begin
    free_idx = '0;
    any_free = 1'b0;
    for (int i = N - 1; i >= 0; i--)
      if (!valid_i[i]) begin
        free_idx = IW'(i);
        any_free = 1'b1;
      end
  end

  assign idx_o = any_free ? free_idx : rr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rr_q <= '0;
    else if (alloc_i && !any_free)
      rr_q <= (rr_q == IW'(N - 1)) ? '0 : rr_q + IW'(1);
  end
endmodule

// File: rtl/bht_table.sv
module bht_table
  import bht_pkg::*;
#(
  parameter int ENTRIES    = 8,
  parameter int ADDR_W     = 32,
  parameter int INSN_BYTES = 4,
  localparam int IW        = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] lk_pc_i,
  output logic              lk_hit_o,
  output logic              lk_taken_o,
  output logic [ADDR_W-1:0] lk_target_o,
  output logic [ADDR_W-1:0] lk_next_pc_o,
  input  logic              up_valid_i,
  input  logic [ADDR_W-1:0] up_pc_i,
  input  logic              up_taken_i,
  input  logic [ADDR_W-1:0] up_target_i
);
  logic [ENTRIES-1:0]             valid_vec;
  logic [ENTRIES-1:0][ADDR_W-1:0] tag_vec, tgt_vec;
  ctr_t [ENTRIES-1:0]             ctr_vec;

  logic [ENTRIES-1:0] lk_hit_vec, up_hit_vec;
  logic [IW-1:0]      lk_idx, up_idx, vic_idx;
  logic               up_hit;

  bht_match #(.N(ENTRIES), .AW(ADDR_W)) u_lk_match (
    .tags_i(tag_vec), .valid_i(valid_vec), .key_i(lk_pc_i),
    .hit_vec_o(lk_hit_vec), .hit_o(lk_hit_o), .idx_o(lk_idx)
  );

  bht_match #(.N(ENTRIES), .AW(ADDR_W)) u_up_match (
    .tags_i(tag_vec), .valid_i(valid_vec), .key_i(up_pc_i),
    .hit_vec_o(up_hit_vec), .hit_o(up_hit), .idx_o(up_idx)
  );

  bht_victim #(.N(ENTRIES)) u_victim (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_vec),
    .alloc_i(up_valid_i && !up_hit), .idx_o(vic_idx)
  );

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic              v_q;
    logic [ADDR_W-1:0] tag_q, tgt_q;
    ctr_t              ctr_q;
    logic              hit_wr, new_wr;

    assign hit_wr = up_valid_i && up_hit && (up_idx == IW'(e));
    assign new_wr = up_valid_i && !up_hit && (vic_idx == IW'(e));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q   <= 1'b0;
        tag_q <= '0;
        tgt_q <= '0;
        ctr_q <= CTR_SNT;
      end else if (new_wr) begin
        v_q   <= 1'b1;
        tag_q <= up_pc_i;
        tgt_q <= up_target_i;
        ctr_q <= ctr_seed(up_taken_i);
      end else if (hit_wr) begin
        tgt_q <= up_target_i;
        ctr_q <= ctr_step(ctr_q, up_taken_i);
      end
    end

    assign valid_vec[e] = v_q;
    assign tag_vec[e]   = tag_q;
    assign tgt_vec[e]   = tgt_q;
    assign ctr_vec[e]   = ctr_q;
  end

  // lookup reads registered state only: same-cycle update is seen next cycle
  assign lk_taken_o   = lk_hit_o && ctr_vec[lk_idx][1];
  assign lk_target_o  = lk_hit_o ? tgt_vec[lk_idx] : '0;
  assign lk_next_pc_o = lk_taken_o ? tgt_vec[lk_idx] : lk_pc_i + ADDR_W'(INSN_BYTES);
endmodule

// File: rtl/bht_table_chk.sv
module bht_table_chk #(
  parameter int N          = 8,
  parameter int AW         = 32,
  parameter int INSN_BYTES = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] lk_pc_i,
  input logic          lk_hit_o,
  input logic          lk_taken_o,
  input logic [AW-1:0] lk_target_o,
  input logic [AW-1:0] lk_next_pc_o,
  input logic          up_valid_i,
  input logic [AW-1:0] up_pc_i,
  input logic [N-1:0]  lk_hit_vec,
  input logic [N-1:0]  valid_vec
);
  // R2
  miss_fallthrough_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_hit_o |-> (!lk_taken_o && lk_next_pc_o == lk_pc_i + AW'(INSN_BYTES)));

  // R3
  taken_redirect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_hit_o && lk_taken_o) |-> (lk_next_pc_o == lk_target_o));

  // R10
  single_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lk_hit_vec));

  // R8
  valid_grow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(valid_vec) >= $past($countones(valid_vec)));

  // R1
  idle_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !up_valid_i |=> $stable(valid_vec));

  // R5
  update_visible_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_valid_i |=> ((lk_pc_i != $past(up_pc_i)) || lk_hit_o));
endmodule

bind bht_table bht_table_chk #(.N(ENTRIES), .AW(ADDR_W), .INSN_BYTES(INSN_BYTES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .lk_pc_i(lk_pc_i), .lk_hit_o(lk_hit_o),
  .lk_taken_o(lk_taken_o), .lk_target_o(lk_target_o), .lk_next_pc_o(lk_next_pc_o),
  .up_valid_i(up_valid_i), .up_pc_i(up_pc_i), .lk_hit_vec(lk_hit_vec),
  .valid_vec(valid_vec)
);

// File: tb/sim_bht_table.sv
`timescale 1ns/1ps
module sim_bht_table;
  localparam int N  = 8;
  localparam int AW = 32;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] lk_pc_i = '0;
  logic          lk_hit_o, lk_taken_o;
  logic [AW-1:0] lk_target_o, lk_next_pc_o;
  logic          up_valid_i = 1'b0;
  logic [AW-1:0] up_pc_i = '0;
  logic          up_taken_i = 1'b0;
  logic [AW-1:0] up_target_i = '0;

  int total = 0;
  int bad = 0;

  bht_table #(.ENTRIES(N), .ADDR_W(AW), .INSN_BYTES(4)) u0 (.*);

  always #10 clk_i = ~clk_i;

  // reference model
  logic          m_v   [N];
  logic [AW-1:0] m_tag [N];
  logic [AW-1:0] m_tgt [N];
  logic [1:0]    m_ctr [N];
  int            m_rr;

  function automatic int m_find(logic [AW-1:0] pc);
    for (int i = 0; i < N; i++) if (m_v[i] && m_tag[i] == pc) return i;
    return -1;
  endfunction

  task automatic m_clear();
    for (int i = 0; i < N; i++) m_v[i] = 1'b0;
    m_rr = 0;
  endtask

  task automatic m_apply(logic [AW-1:0] pc, logic tk, logic [AW-1:0] tg);
    int k = m_find(pc);
    if (k >= 0) begin
      m_tgt[k] = tg;
      if (tk) m_ctr[k] = (m_ctr[k] == 2'd3) ? 2'd3 : m_ctr[k] + 2'd1;
      else    m_ctr[k] = (m_ctr[k] == 2'd0) ? 2'd0 : m_ctr[k] - 2'd1;
    end else begin
      k = -1;
      for (int i = N - 1; i >= 0; i--) if (!m_v[i]) k = i;
      if (k < 0) begin k = m_rr; m_rr = (m_rr + 1) % N; end
      m_v[k] = 1'b1; m_tag[k] = pc; m_tgt[k] = tg;
      m_ctr[k] = tk ? 2'b10 : 2'b01;
    end
  endtask

  task automatic chk(logic ok, string req, logic [67:0] act, logic [67:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // compare {hit,taken,target,next} to model
  task automatic look(logic [AW-1:0] pc, string req);
    int k;
    logic h, t;
    logic [AW-1:0] tg, nx;
    lk_pc_i = pc;
    #1;
    k  = m_find(pc);
    h  = (k >= 0);
    t  = h && m_ctr[k][1];
    tg = h ? m_tgt[k] : '0;
    nx = t ? m_tgt[k] : pc + 32'd4;
    chk({lk_hit_o, lk_taken_o, lk_target_o, lk_next_pc_o} == {h, t, tg, nx}, req,
        {2'b0, lk_hit_o, lk_taken_o, lk_target_o, lk_next_pc_o}, {2'b0, h, t, tg, nx});
  endtask

  task automatic upd(logic [AW-1:0] pc, logic tk, logic [AW-1:0] tg);
    @(negedge clk_i);
    up_valid_i = 1'b1; up_pc_i = pc; up_taken_i = tk; up_target_i = tg;
    @(posedge clk_i);
    m_apply(pc, tk, tg);
    @(negedge clk_i);
    up_valid_i = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    m_clear();
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    m_clear();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 R2: empty table after reset, fall-through
    for (int i = 0; i < 6; i++) look(32'h40 + i * 4, "R1");
    look(32'hFFFF_FFFC, "R2");

    // R4 R5 R8: every 4-outcome history from both seeds, 32 branches into 8 slots
    for (int s = 0; s < 2; s++)
      for (int q = 0; q < 16; q++) begin
        logic [AW-1:0] pc = 32'h1000 + (s * 16 + q) * 16;
        upd(pc, s[0], pc + 32'h400);
        look(pc, "R5");
        for (int b = 0; b < 4; b++) begin
          upd(pc, q[b], pc + 32'h800 + b);
          look(pc, "R4");
        end
      end
    for (int i = 0; i < 32; i++) look(32'h1000 + i * 16, "R8");

    // R7: loop exit from strong taken, and mirror from strong not-taken
    do_reset();
    upd(32'h2000, 1'b1, 32'h1F00);
    upd(32'h2000, 1'b1, 32'h1F00);
    upd(32'h2000, 1'b0, 32'h1F00);
    look(32'h2000, "R7");
    chk(lk_taken_o == 1'b1, "R7", {67'b0, lk_taken_o}, 68'd1);
    upd(32'h2100, 1'b0, 32'h3000);
    upd(32'h2100, 1'b0, 32'h3000);
    upd(32'h2100, 1'b1, 32'h3000);
    look(32'h2100, "R7");
    chk(lk_taken_o == 1'b0, "R7", {67'b0, lk_taken_o}, 68'd0);

    // R6: target refresh on hit
    upd(32'h2000, 1'b1, 32'h5550);
    look(32'h2000, "R6");
    chk(lk_target_o == 32'h5550, "R6", {36'b0, lk_target_o}, {36'b0, 32'h5550});

    // R9: collision reads old state, new state next cycle
    upd(32'h2200, 1'b1, 32'h7000);
    @(negedge clk_i);
    up_valid_i = 1'b1; up_pc_i = 32'h2200; up_taken_i = 1'b0; up_target_i = 32'h7100;
    look(32'h2200, "R9");
    chk(lk_taken_o == 1'b1, "R9", {67'b0, lk_taken_o}, 68'd1);
    @(posedge clk_i);
    m_apply(32'h2200, 1'b0, 32'h7100);
    @(negedge clk_i);
    up_valid_i = 1'b0;
    look(32'h2200, "R9");
    chk(lk_taken_o == 1'b0, "R9", {67'b0, lk_taken_o}, 68'd0);

    // R10: repeated updates use one slot, leaving room for 7 more
    do_reset();
    for (int i = 0; i < 3; i++) upd(32'h3000, 1'b1, 32'h3100);
    for (int i = 1; i < 8; i++) upd(32'h3000 + i * 8, 1'b0, 32'h9000);
    for (int i = 0; i < 8; i++) begin
      look(32'h3000 + i * 8, "R10");
      chk(lk_hit_o == 1'b1, "R10", {67'b0, lk_hit_o}, 68'd1);
    end

    // R3: hit outputs for a taken and a not-taken slot
    look(32'h3000, "R3");
    look(32'h3008, "R3");

    // R1: reset mid-run clears everything
    do_reset();
    look(32'h3000, "R1");
    chk(lk_hit_o == 1'b0, "R1", {67'b0, lk_hit_o}, 68'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #4000000;
    total++;
    bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule